// File: doc/BRIEF.md
# Audio Delay Line Controller

This block runs a bit-serial audio delay line. The delay line lives in an external dynamic RAM that is one bit wide for each audio channel, and every channel's RAM shares the same address and strobe lines. Each sample period is one fixed memory cycle. First the block reads the bit stored at the current location and hands it to the demodulator side as the delayed bit. It then writes the fresh modulator bit back into that same location. A location is therefore read again exactly one buffer length later, so the buffer length in sample periods is the delay.

The address is split into a row part and a column part. Both parts share one multiplexed bus, and the strobe pattern of the cycle decides which part is on the bus. A two-bit selector picks one of four buffer lengths. A new selection is only taken up when the counter returns to zero. Each channel has a bypass control that routes its live input straight to its output, and the delay line keeps recording while a channel is bypassed. A memory cycle is seven phases long. Each phase lasts `DIV` clocks, which sets the sample rate.

Top module: `audio_delay_ctrl`

## Requirements
- R1: While reset is held, the row strobe, column strobe, write strobe and output enable all sit high (inactive), and every delayed output bit is 0.
- R2: One memory cycle is seven phases of `DIV` clocks each. The row strobe falls once per cycle (every 7*DIV clocks) and stays low for six phases.
- R3: During the read phases the output enable is low and the write strobe is high. During the write phases the write strobe is low and the output enable is high. The column strobe is never low while the row strobe is high. The last phase of each cycle has all four strobes high.
- R4: When the row strobe falls, the bus carries the upper `ROW_W` address bits. When the column strobe falls, the bus carries the lower `COL_W` bits. The read and the write of one cycle use the same address.
- R5: The address starts at 0 after reset and steps by one per cycle. After the last location of the active length (`LEN0`..`LEN3`) it goes back to 0.
- R6: Once the first full pass is complete, the delayed bit a channel shows in a cycle is the bit that the same location stored one buffer pass earlier. With a constant length L, this is the input from L cycles before.
- R7: Until the counter has wrapped once after reset, every delayed bit reads as 0, whatever the memory returns.
- R8: Selector code 0, 1, 2 or 3 picks `LEN0`, `LEN1`, `LEN2` or `LEN3`. A change during a pass does not take effect until the next return to 0. The value present during the first cycle after reset sets the first pass.
- R9: A channel's delayed bit changes only at the end of the third phase of a cycle, and then holds for a whole cycle.
- R10: The input bit is sampled once per cycle, on entry to the write phases. Changes made after that point in the cycle are not stored.
- R11: A bypassed channel's output follows its input combinationally. The other channel is not affected, and the bypassed channel's input is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dly_sel_i | input | 2 | Buffer length selector |
| bypass_i | input | NCH | Per-channel bypass, 1 = input passes straight through |
| mod_bit_i | input | NCH | Modulator bit for each channel |
| demod_bit_o | output | NCH | Delayed (or bypassed) bit for each channel |
| mem_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_ras_n_o | output | 1 | Row strobe, active low |
| mem_cas_n_o | output | 1 | Column strobe, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_wdata_o | output | NCH | Data bits written to the memories |
| mem_rdata_i | input | NCH | Data bits read from the memories |

## Verification
The hardest situation to reach is a length change in the middle of a pass. The old length has to finish, and the first pass at a longer length then reads locations that the shorter length never wrote. The stimulus table changes the selector one cycle after a wrap and later changes it again in mid-pass. A behavioural memory in the bench, together with a reference circular buffer, supplies the expected stale contents. A second reset in mid-run, taken while the memory still holds old data, shows that the output stays silent for the whole first pass.

// File: rtl/dlyc_pkg.sv
package dlyc_pkg;

    typedef enum logic [2:0] {
        PH_RAS   = 3'd0,
        PH_RDCAS = 3'd1,
        PH_RDLAT = 3'd2,
        PH_WSET  = 3'd3,
        PH_WCAS  = 3'd4,
        PH_WHOLD = 3'd5,
        PH_PRE   = 3'd6
    } phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strb_t;

    localparam strb_t STRB_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    // strobe pattern driven while a phase is active
    function automatic strb_t phase_strobes(phase_e p);
        strb_t s;
        s = STRB_IDLE;
        case (p)
            PH_RAS:   s.ras_n = 1'b0;
            PH_RDCAS,
            PH_RDLAT: begin s.ras_n = 1'b0; s.cas_n = 1'b0; s.oe_n = 1'b0; end
            PH_WSET:  begin s.ras_n = 1'b0; s.we_n = 1'b0; end
            PH_WCAS:  begin s.ras_n = 1'b0; s.cas_n = 1'b0; s.we_n = 1'b0; end
            PH_WHOLD: s.ras_n = 1'b0;
            default:  s = STRB_IDLE;
        endcase
        return s;
    endfunction

    // phases during which the column half owns the address bus
    function automatic logic phase_is_col(phase_e p);
        return (p != PH_RAS) && (p != PH_PRE);
    endfunction

endpackage

// File: rtl/dlyc_tick.sv
module dlyc_tick #(
    parameter int DIV = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_gap
            assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/dlyc_seq.sv
module dlyc_seq
    import dlyc_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  tick_i,
    output strb_t strb_o,
    output logic  col_sel_o,
    output logic  rd_latch_o,
    output logic  step_o
);
    typedef struct packed {
        phase_e ph;
        strb_t  st;
        logic   col;
    } seq_t;

    localparam seq_t SEQ_RST = '{ph: PH_RAS, st: STRB_IDLE, col: 1'b0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (tick_i) begin
            seq_d.ph = (seq_q.ph == PH_PRE) ? PH_RAS : phase_e'(seq_q.ph + 3'd1);
        end
        seq_d.st  = phase_strobes(seq_d.ph);
        seq_d.col = phase_is_col(seq_d.ph);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= SEQ_RST;
        else         seq_q <= seq_d;
    end

    assign strb_o     = seq_q.st;
    assign col_sel_o  = seq_q.col;
    assign rd_latch_o = tick_i && (seq_q.ph == PH_RDLAT);
    assign step_o     = tick_i && (seq_q.ph == PH_WHOLD);

    assert_cas_in_ras_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strb_o.cas_n |-> !strb_o.ras_n);
    assert_oe_we_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!strb_o.oe_n && !strb_o.we_n));
    assert_phase_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && seq_q.ph == PH_PRE) |=> (seq_q.ph == PH_RAS));
    assert_phase_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(seq_q.ph));
endmodule

// File: rtl/dlyc_addr.sv
module dlyc_addr #(
    parameter int ROW_W = 11,
    parameter int COL_W = 11,
    parameter int LEN0  = 15500,
    parameter int LEN1  = 31000,
    parameter int LEN2  = 46500,
    parameter int LEN3  = 62000,
    localparam int AW    = ROW_W + COL_W,
    localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             col_sel_i,
    input  logic [1:0]       sel_i,
    output logic [BUS_W-1:0] bus_o,
    output logic             primed_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    sel;
        logic          fresh;
        logic          primed;
    } adr_t;

    localparam adr_t ADR_RST = '{addr: '0, sel: 2'd0, fresh: 1'b1, primed: 1'b0};

    function automatic logic [AW:0] len_of(logic [1:0] s);
        case (s)
            2'd0:    return (AW+1)'(LEN0);
            2'd1:    return (AW+1)'(LEN1);
            2'd2:    return (AW+1)'(LEN2);
            default: return (AW+1)'(LEN3);
        endcase
    endfunction

    adr_t        adr_d, adr_q;
    logic [AW:0] last_loc;

    always_comb begin
        adr_d    = adr_q;
        last_loc = len_of(adr_q.sel) - 1'b1;
        if (adr_q.fresh) adr_d.sel = sel_i;
        if (step_i) begin
            adr_d.fresh = 1'b0;
            if ({1'b0, adr_q.addr} == last_loc) begin
                adr_d.addr   = '0;
                adr_d.primed = 1'b1;
                adr_d.sel    = sel_i;
            end else begin
                adr_d.addr = adr_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) adr_q <= ADR_RST;
        else         adr_q <= adr_d;
    end

    always_comb begin
        bus_o = '0;
        if (col_sel_i) bus_o[COL_W-1:0] = adr_q.addr[COL_W-1:0];
        else           bus_o[ROW_W-1:0] = adr_q.addr[AW-1:COL_W];
    end

    assign primed_o = adr_q.primed;

    assert_addr_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, adr_q.addr} < len_of(adr_q.sel));
    assert_addr_step_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(adr_q.addr));
    assert_primed_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adr_q.primed |=> adr_q.primed);
    assert_sel_mid_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adr_q.fresh && !step_i) |=> $stable(adr_q.sel));
endmodule

// File: rtl/dlyc_data.sv
module dlyc_data #(
    parameter int NCH = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           rd_latch_i,
    input  logic           primed_i,
    input  logic [NCH-1:0] rdata_i,
    input  logic [NCH-1:0] mod_i,
    input  logic [NCH-1:0] byp_i,
    output logic [NCH-1:0] wdata_o,
    output logic [NCH-1:0] out_o
);
    typedef struct packed {
        logic [NCH-1:0] dly;
        logic [NCH-1:0] wr;
    } dat_t;

    dat_t dat_d, dat_q;

    always_comb begin
        dat_d = dat_q;
        if (rd_latch_i) begin
            dat_d.dly = primed_i ? rdata_i : '0;
            dat_d.wr  = mod_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dat_q <= '0;
        else         dat_q <= dat_d;
    end

    assign wdata_o = dat_q.wr;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            assign out_o[g] = byp_i[g] ? mod_i[g] : dat_q.dly[g];
        end
    endgenerate

    assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_latch_i |=> $stable(dat_q.dly));
    assert_wdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_latch_i |=> $stable(dat_q.wr));
    assert_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !primed_i |-> (dat_q.dly == '0));
endmodule

// File: rtl/audio_delay_ctrl.sv
module audio_delay_ctrl
    import dlyc_pkg::*;
#(
    parameter int DIV   = 8,
    parameter int NCH   = 2,
    parameter int ROW_W = 11,
    parameter int COL_W = 11,
    parameter int LEN0  = 15500,
    parameter int LEN1  = 31000,
    parameter int LEN2  = 46500,
    parameter int LEN3  = 62000,
    localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       dly_sel_i,
    input  logic [NCH-1:0]   bypass_i,
    input  logic [NCH-1:0]   mod_bit_i,
    output logic [NCH-1:0]   demod_bit_o,
    output logic [BUS_W-1:0] mem_addr_o,
    output logic             mem_ras_n_o,
    output logic             mem_cas_n_o,
    output logic             mem_we_n_o,
    output logic             mem_oe_n_o,
    output logic [NCH-1:0]   mem_wdata_o,
    input  logic [NCH-1:0]   mem_rdata_i
);
    logic  tick, col_sel, rd_latch, step, primed;
    strb_t strb;

    dlyc_tick #(.DIV(DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    dlyc_seq u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .strb_o     (strb),
        .col_sel_o  (col_sel),
        .rd_latch_o (rd_latch),
        .step_o     (step)
    );

    dlyc_addr #(
        .ROW_W (ROW_W), .COL_W (COL_W),
        .LEN0  (LEN0),  .LEN1  (LEN1), .LEN2 (LEN2), .LEN3 (LEN3)
    ) u_addr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step),
        .col_sel_i (col_sel),
        .sel_i     (dly_sel_i),
        .bus_o     (mem_addr_o),
        .primed_o  (primed)
    );

    dlyc_data #(.NCH(NCH)) u_data (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_latch_i (rd_latch),
        .primed_i   (primed),
        .rdata_i    (mem_rdata_i),
        .mod_i      (mod_bit_i),
        .byp_i      (bypass_i),
        .wdata_o    (mem_wdata_o),
        .out_o      (demod_bit_o)
    );

    assign mem_ras_n_o = strb.ras_n;
    assign mem_cas_n_o = strb.cas_n;
    assign mem_we_n_o  = strb.we_n;
    assign mem_oe_n_o  = strb.oe_n;

    assert_latch_in_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_latch |-> (!mem_cas_n_o && !mem_oe_n_o));
    assert_step_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step |-> (!mem_ras_n_o && mem_cas_n_o && mem_we_n_o));
endmodule

// File: tb/sim_audio_delay_ctrl.sv
module sim_audio_delay_ctrl;
    localparam int DIV = 2, NCH = 2, RW = 3, CW = 3;
    localparam int L0 = 4, L1 = 6, L2 = 8, L3 = 10;
    localparam int NVEC = 56;

    // vector: {sel[1:0], in[1:0], flip, bypass[1:0]}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b00_01_0_00, 7'b00_10_0_00, 7'b00_11_1_00, 7'b00_00_0_00,
        7'b00_11_0_00, 7'b00_01_1_00, 7'b00_10_0_00, 7'b00_00_1_00,
        7'b00_11_0_00, 7'b00_10_0_00, 7'b00_01_0_00, 7'b00_00_0_00,
        7'b00_11_0_00, 7'b01_01_0_00, 7'b01_10_1_00, 7'b01_11_0_00,
        7'b01_00_0_00, 7'b01_01_0_00, 7'b01_11_0_00, 7'b01_10_0_00,
        7'b01_01_0_01, 7'b01_11_1_01, 7'b01_00_0_10, 7'b01_10_0_11,
        7'b01_01_0_00, 7'b01_11_0_00, 7'b01_00_1_00, 7'b01_10_0_00,
        7'b11_01_0_00, 7'b11_10_0_00, 7'b11_11_0_00, 7'b11_00_1_00,
        7'b11_01_0_00, 7'b11_10_0_00, 7'b11_11_0_00, 7'b11_01_0_00,
        7'b11_00_0_00, 7'b11_10_1_00, 7'b11_11_0_00, 7'b11_01_0_00,
        7'b10_10_0_00, 7'b10_00_0_00, 7'b10_11_0_00, 7'b10_01_0_00,
        7'b10_10_0_00, 7'b10_11_0_00, 7'b10_00_1_00, 7'b10_01_0_00,
        7'b10_11_0_00, 7'b10_10_0_00, 7'b10_01_0_00, 7'b10_00_0_00,
        7'b10_11_0_00, 7'b10_01_0_00, 7'b10_10_0_00, 7'b10_11_0_00
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [NCH-1:0] byp = '0, mod = '0, demod, wdata, rdata;
    logic [CW-1:0] abus;
    logic ras_n, cas_n, we_n, oe_n;

    int checks = 0, errors = 0, clk_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) clk_cnt <= clk_cnt + 1;

    audio_delay_ctrl #(
        .DIV(DIV), .NCH(NCH), .ROW_W(RW), .COL_W(CW),
        .LEN0(L0), .LEN1(L1), .LEN2(L2), .LEN3(L3)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n), .dly_sel_i(sel), .bypass_i(byp),
        .mod_bit_i(mod), .demod_bit_o(demod), .mem_addr_o(abus),
        .mem_ras_n_o(ras_n), .mem_cas_n_o(cas_n), .mem_we_n_o(we_n),
        .mem_oe_n_o(oe_n), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
    );

    // behavioural memory, one bit per channel, sampled away from the active edge
    logic [NCH-1:0] mem [64];
    logic [RW-1:0] row_cap = '0;
    logic [CW-1:0] col_cap = '0, col_rd = '0, col_wr = '0;
    logic pr = 1'b1, pc = 1'b1, pw = 1'b1;
    event ev_start, ev_wset, ev_pre;

    initial for (int i = 0; i < 64; i++) mem[i] = '0;

    always @(negedge clk) begin
        if (pr && !ras_n) begin row_cap = abus[RW-1:0]; -> ev_start; end
        if (!pr && ras_n) -> ev_pre;
        if (pc && !cas_n) begin
            col_cap = abus;
            if (!we_n) begin col_wr = abus; mem[{row_cap, abus}] = wdata; end
            else col_rd = abus;
        end
        if (pw && !we_n) -> ev_wset;
        pr = ras_n; pc = cas_n; pw = we_n;
    end

    assign rdata = (!cas_n && !oe_n) ? mem[{row_cap, col_cap}] : '0;

    // reference circular buffer built from the requirements
    logic [NCH-1:0] ref_mem [64];
    int ref_addr = 0, ref_len = L0;
    bit ref_primed = 1'b0;
    logic [NCH-1:0] prev_exp = '0;

    function automatic int len_of(logic [1:0] s);
        case (s)
            2'd0: return L0;
            2'd1: return L1;
            2'd2: return L2;
            default: return L3;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ref_reset();
        ref_addr = 0; ref_len = len_of(sel); ref_primed = 1'b0; prev_exp = '0;
    endtask

    task automatic run_cycle(input logic [1:0] s, input logic [1:0] in,
                             input logic flip, input logic [1:0] b);
        logic [NCH-1:0] exp;
        @(ev_start);
        for (int c = 0; c < NCH; c++)
            if (!byp[c]) chk("R9 held from previous cycle", 32'(demod[c]), 32'(prev_exp[c]));
        chk("R3 row phase strobes", {cas_n, we_n, oe_n}, 3'b111);
        sel = s; mod = in; byp = b;
        @(ev_wset);
        chk("R3 write phase strobes", {ras_n, oe_n}, 2'b01);
        if (flip) mod = ~in;          // R10: after the sample point, must not be stored
        @(ev_pre);
        exp = ref_primed ? ref_mem[ref_addr] : '0;
        for (int c = 0; c < NCH; c++) begin
            if (b[c]) chk("R11 bypass follows input", 32'(demod[c]), 32'(mod[c]));
            else if (ref_primed) chk("R6 R8 R10 delayed bit", 32'(demod[c]), 32'(exp[c]));
            else chk("R7 silent first pass", 32'(demod[c]), 32'(exp[c]));
        end
        chk("R4 R5 R8 read address", 32'({row_cap, col_rd}), 32'(ref_addr));
        chk("R4 write column equals read column", 32'(col_wr), 32'(col_rd));
        chk("R3 precharge strobes", {ras_n, cas_n, we_n, oe_n}, 4'hF);
        ref_mem[ref_addr] = in;
        prev_exp = exp;
        if (ref_addr == ref_len - 1) begin
            ref_addr = 0; ref_len = len_of(s); ref_primed = 1'b1;
        end else ref_addr++;
    endtask

    initial begin
        int n0, n1, n2;
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 strobes idle in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
        chk("R1 outputs zero in reset", 32'(demod), 32'd0);
        rst_n = 1'b1;
        ref_reset();
        for (int v = 0; v < NVEC; v++)
            run_cycle(VEC[v][6:5], VEC[v][4:3], VEC[v][2], VEC[v][1:0]);

        // R2 cycle period and row strobe width
        @(ev_start); n0 = clk_cnt;
        @(ev_pre);   n1 = clk_cnt;
        @(ev_start); n2 = clk_cnt;
        chk("R2 cycle length", 32'(n2 - n0), 32'(7 * DIV));
        chk("R2 row strobe low time", 32'(n1 - n0), 32'(6 * DIV));

        // mid-run reset: memory keeps old data, output must stay silent for a pass
        @(negedge clk); @(negedge clk);
        rst_n = 1'b0; byp = '0; sel = 2'd2;
        @(negedge clk);
        chk("R1 strobes idle in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
        chk("R1 outputs zero in reset", 32'(demod), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        ref_reset();
        for (int k = 0; k < 12; k++)
            run_cycle(2'd2, 2'(k + 1), 1'b0, 2'b00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule